// File: doc/BRIEF.md
# DDS Sine Tone Generator

This block turns a phase-increment tuning word into a stream of sine-wave samples at a fixed audio sample rate. A free-running divider produces one sample tick every `CLK_DIV` clocks: 2283 clocks of a 100 MHz clock give a rate of about 43.80 kHz, which stands in for the usual 44.1 kHz audio rate. On each tick a 24-bit phase accumulator adds the tuning word. The top bits of the phase address a 256-entry sine table, so a larger tuning word produces a higher tone.

Each sample is a 12-bit unsigned code in which 2048 means zero, so a unipolar serial DAC can take it as it is. Every new sample comes with a one-clock strobe that a downstream DAC shifter can use to start a transfer. The tuning word comes from the pitch-decoding stage. When the note is off (`tone_en` low), the generator outputs mid-scale and holds its phase at zero, so the next note always starts at phase zero.

Top module: `tone_synth`

## Requirements
- R1: While reset is high and on the first clock after it, `sample` is 2048 and `sample_valid` is 0.
- R2: `sample_valid` is a pulse exactly one clock wide. Consecutive pulses are exactly `CLK_DIV` clocks apart, whether or not the tone is enabled.
- R3: Count samples from the moment `tone_en` rises, starting at n = 0. Sample n is read from the table at phase (n·m) mod 2^24, where m is the tuning word. The phase register wraps modulo 2^24.
- R4: The table index is phase bits [23:16]. Entry i lies within ±4 codes of round(2048 + 2047·sin(2πi/256)).
- R5: Table entries 0 and 128 are exactly 2048, entry 64 is exactly 4095 and entry 192 is exactly 1. No sample is ever 0.
- R6: While `tone_en` is low, the phase register stays at 0, pulses continue at the tick rate, and every sample is 2048.
- R7: A change of tuning word takes effect at the next tick and does not reset the phase. The phase keeps accumulating from where it was.
- R8: When `tone_en` falls, `sample` is 2048 on the next clock edge. When it is raised again, the first sample is read at phase zero.
- R9: `sample` changes only on a clock where `sample_valid` is high, or to the value 2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_en | input | 1 | Note active; low silences the output to mid-scale |
| tune_word | input | ACC_W (24) | Phase increment added on every sample tick |
| sample | output | SAMP_W (12) | Offset-binary sine sample, 2048 = zero |
| sample_valid | output | 1 | One-clock strobe marking a new sample |

## Verification
The hardest case to reach from the ports is a tuning-word change in the middle of a note. The continuity requirement only shows up if the bench knows exactly which tick used the old word and which used the new one. The bench changes the word on the clock just after a strobe. It knows the increment for that sample was applied two clocks earlier, so it adds the old word to its phase model before switching. It then checks every later sample against the continued phase. The four exact quarter-wave codes are only reached when the phase lands on those entries, so one test steps exactly one table entry per sample through a full period and past the wrap.

// File: rtl/tone_pkg.sv
package tone_pkg;

  localparam int unsigned DEF_ACC_W  = 24;
  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_SAMP_W = 12;
  localparam int unsigned DEF_DIV    = 2283;

  // Half-wave rational approximation of sine, mapped to offset binary.
  // For k in one half period of length h: mag = amp*16p/(5h^2-4p), p=k(h-k).
  function automatic int unsigned sine_code(int unsigned idx,
                                            int unsigned addr_w,
                                            int unsigned samp_w);
    longint half;
    longint k;
    longint p;
    longint amp;
    longint num;
    longint den;
    longint mag;
    longint mid;
    half = longint'(1) << (addr_w - 1);
    k    = longint'(idx) % half;
    p    = k * (half - k);
    mid  = longint'(1) << (samp_w - 1);
    amp  = mid - 1;
    num  = amp * 16 * p;
    den  = 5 * half * half - 4 * p;
    mag  = (num + den / 2) / den;
    if (longint'(idx) < half) return int'(mid + mag);
    else                      return int'(mid - mag);
  endfunction

endpackage

// File: rtl/sample_tick_gen.sv
module sample_tick_gen #(
  parameter int unsigned DIV = tone_pkg::DEF_DIV
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/phase_accum.sv
module phase_accum #(
  parameter int unsigned ACC_W = tone_pkg::DEF_ACC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             step,
  input  logic [ACC_W-1:0] incr,
  output logic [ACC_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst || clear) phase <= '0;
    else if (step)    phase <= phase + incr;
  end
endmodule

// File: rtl/sine_rom.sv
module sine_rom #(
  parameter int unsigned ADDR_W = tone_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = tone_pkg::DEF_SAMP_W
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int unsigned i = 0; i < DEPTH; i++)
      mem[i] = DATA_W'(tone_pkg::sine_code(i, ADDR_W, DATA_W));
  end

  always_ff @(posedge clk) begin
    if (rd_en) q <= mem[addr];
  end
endmodule

// File: rtl/tone_synth.sv
module tone_synth #(
  parameter int unsigned CLK_DIV = tone_pkg::DEF_DIV,
  parameter int unsigned ACC_W   = tone_pkg::DEF_ACC_W,
  parameter int unsigned ADDR_W  = tone_pkg::DEF_ADDR_W,
  parameter int unsigned SAMP_W  = tone_pkg::DEF_SAMP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tone_en,
  input  logic [ACC_W-1:0]  tune_word,
  output logic [SAMP_W-1:0] sample,
  output logic              sample_valid
);
  localparam logic [SAMP_W-1:0] MID = SAMP_W'(1) << (SAMP_W - 1);

  logic              tick;
  logic [ACC_W-1:0]  phase_q;
  logic [SAMP_W-1:0] rom_q;
  logic              rd_q;
  logic              live_q;

  sample_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  phase_accum #(.ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst   (rst),
    .clear (~tone_en),
    .step  (tick),
    .incr  (tune_word),
    .phase (phase_q)
  );

  sine_rom #(.ADDR_W(ADDR_W), .DATA_W(SAMP_W)) u_rom (
    .clk   (clk),
    .rd_en (tick),
    .addr  (phase_q[ACC_W-1 -: ADDR_W]),
    .q     (rom_q)
  );

  // Read stage: remembers that a table word is arriving and whether the note was live.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q   <= 1'b0;
      live_q <= 1'b0;
    end else begin
      rd_q   <= tick;
      live_q <= tone_en;
    end
  end

  // Output stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      sample       <= MID;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= rd_q;
      if (!tone_en)  sample <= MID;
      else if (rd_q) sample <= live_q ? rom_q : MID;
    end
  end
endmodule

// File: rtl/tone_synth_chk.sv
module tone_synth_chk #(
  parameter int unsigned CLK_DIV = tone_pkg::DEF_DIV,
  parameter int unsigned ACC_W   = tone_pkg::DEF_ACC_W,
  parameter int unsigned SAMP_W  = tone_pkg::DEF_SAMP_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tone_en,
  input logic [SAMP_W-1:0] sample,
  input logic              sample_valid,
  input logic [ACC_W-1:0]  phase
);
  localparam logic [SAMP_W-1:0] MID = SAMP_W'(1) << (SAMP_W - 1);
  localparam int unsigned GW = $clog2(CLK_DIV) + 1;

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (sample_valid) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap  <= gap + 1'b1;
    end
  end

  p_valid_single_r2: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  p_valid_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && seen) |-> (gap == GW'(CLK_DIV - 1)));

  p_idle_phase_r6: assert property (@(posedge clk) disable iff (rst)
    !tone_en |=> (phase == '0));

  p_mute_mid_r8: assert property (@(posedge clk) disable iff (rst)
    !tone_en |=> (sample == MID));

  p_never_zero_r5: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (sample != '0));

  p_sample_holds_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sample) |-> (sample_valid || sample == MID));
endmodule

bind tone_synth tone_synth_chk #(
  .CLK_DIV (CLK_DIV),
  .ACC_W   (ACC_W),
  .SAMP_W  (SAMP_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .tone_en      (tone_en),
  .sample       (sample),
  .sample_valid (sample_valid),
  .phase        (phase_q)
);

// File: tb/tone_synth_test.sv
module tone_synth_test;
  localparam int DIV = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tone_en = 1'b0;
  logic [23:0] tune_word = '0;
  logic [11:0] sample;
  logic        sample_valid;

  int checks = 0;
  int errors = 0;
  logic [23:0] ph;   // bench phase model

  always #2.5 clk = ~clk;

  tone_synth #(.CLK_DIV(DIV)) uut (
    .clk          (clk),
    .rst          (rst),
    .tone_en      (tone_en),
    .tune_word    (tune_word),
    .sample       (sample),
    .sample_valid (sample_valid)
  );

  function automatic int ideal(int idx);
    return int'(2048.0 + 2047.0 * $sin(2.0 * 3.14159265358979 * idx / 256.0));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic get_sample(output int v);
    v = -1;
    for (int i = 0; i < 4 * DIV; i++) begin
      @(negedge clk);
      if (sample_valid) begin
        v = int'(sample);
        return;
      end
    end
    check(1'b0, "R2 strobe timeout", 0, 1);
  endtask

  // compare with model phase, then advance by the word used at that tick
  task automatic model_check(input int v, input string req);
    int idx;
    int e;
    idx = int'(ph[23:16]);
    e = ideal(idx);
    check((v - e <= 4) && (e - v <= 4), req, v, e);
    if (idx == 0 || idx == 128) check(v == 2048, "R5 zero crossing", v, 2048);
    if (idx == 64)  check(v == 4095, "R5 positive peak", v, 4095);
    if (idx == 192) check(v == 1, "R5 negative peak", v, 1);
    ph = ph + tune_word;
  endtask

  task automatic start_tone(input logic [23:0] m);
    int v;
    tone_en = 1'b0;
    get_sample(v);
    tune_word = m;
    tone_en = 1'b1;
    ph = '0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(sample == 12'd2048, "R1 reset sample", int'(sample), 2048);
    check(!sample_valid, "R1 reset strobe", int'(sample_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(sample == 12'd2048, "R1 first clock sample", int'(sample), 2048);
    check(!sample_valid, "R1 first clock strobe", int'(sample_valid), 0);
  endtask

  task automatic t_period_muted;
    int v;
    int n;
    get_sample(v);
    check(v == 2048, "R6 muted sample", v, 2048);
    for (int r = 0; r < 3; r++) begin
      n = 0;
      @(negedge clk);
      n++;
      check(!sample_valid, "R2 strobe width", int'(sample_valid), 0);
      while (!sample_valid && n < 4 * DIV) begin
        @(negedge clk);
        n++;
      end
      check(n == DIV, "R2 strobe spacing", n, DIV);
      check(sample == 12'd2048, "R6 muted sample", int'(sample), 2048);
    end
  endtask

  task automatic t_step_sweep;
    int v;
    start_tone(24'h01_0000);
    for (int s = 0; s < 260; s++) begin
      get_sample(v);
      model_check(v, "R4 table sweep");
    end
  endtask

  task automatic t_odd_word;
    int v;
    start_tone(24'h35_7A1C);
    get_sample(v);
    check(v == 2048, "R3 first sample at phase zero", v, 2048);
    ph = ph + tune_word;
    for (int s = 0; s < 60; s++) begin
      get_sample(v);
      model_check(v, "R3 accumulate and wrap");
    end
  endtask

  task automatic t_retune;
    int v;
    start_tone(24'h02_3456);
    for (int s = 0; s < 12; s++) begin
      get_sample(v);
      model_check(v, "R7 before retune");
    end
    tune_word = 24'h0B_0F0F;
    for (int s = 0; s < 20; s++) begin
      get_sample(v);
      model_check(v, "R7 after retune");
    end
  endtask

  task automatic t_zero_word;
    int v;
    start_tone(24'h00_0000);
    for (int s = 0; s < 5; s++) begin
      get_sample(v);
      check(v == 2048, "R3 zero word holds phase", v, 2048);
    end
  endtask

  task automatic t_drop_enable;
    int v;
    start_tone(24'h10_0000);
    for (int s = 0; s < 4; s++) begin
      get_sample(v);
      model_check(v, "R8 before drop");
    end
    check(sample != 12'd2048, "R8 nonzero before drop", int'(sample), 4095);
    tone_en = 1'b0;
    @(negedge clk);
    check(sample == 12'd2048, "R8 mute next edge", int'(sample), 2048);
    for (int s = 0; s < 3; s++) begin
      get_sample(v);
      check(v == 2048, "R6 muted after drop", v, 2048);
    end
    tone_en = 1'b1;
    ph = '0;
    for (int s = 0; s < 6; s++) begin
      get_sample(v);
      model_check(v, "R8 restart at phase zero");
    end
  endtask

  initial begin
    t_reset();
    t_period_muted();
    t_step_sweep();
    t_odd_word();
    t_retune();
    t_zero_word();
    t_drop_enable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule